// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces four independent pulse-width-modulated outputs. Software sets them up through a small word-addressed register interface with single-cycle write and read strobes. One shared control word holds a run bit for each channel and a two-bit step-size select for each channel. A separate configuration word per channel holds the period length and the high time, both counted in step ticks.

Each channel divides the input clock by 1, 8, 64 or 512 to form its step tick. It counts steps from zero up to the period length and drives its pin high while the step count is below the high time. Settings written while a channel runs are copied into the channel only at the end of the current period, so the output never shows a shortened or stretched pulse. Disabling a channel forces its pin low at once and clears its counters. Enabling it again starts a clean period.

Top module: `pwm_quad`

## Requirements
- R1: After reset every PWM output is low and every register reads zero.
- R2: The control word sits at byte address 0x00. Bit n is the run bit of channel n. Bits [2n+5:2n+4] hold the step select of channel n. Reads return the written values in bits [11:0], and bits [31:12] read as zero.
- R3: The configuration word of channel n sits at byte address 0x04+4n. Bits [7:0] hold the period length and bits [23:16] hold the high time. All other bits read as zero. Writes to any other address, or to an address whose two low bits are not zero, change nothing, and reads of those addresses return zero.
- R4: Step select codes 0, 1, 2 and 3 make each step last 1, 8, 64 and 512 input clocks.
- R5: A running channel repeats a period of (period length) steps. The output is high for the first (high time) steps of each period and low for the rest.
- R6: A high time of 0 keeps the output low all the time. A high time equal to the period length keeps it high all the time.
- R7: A period length of 0 keeps a running channel's output low.
- R8: A new period length, high time or step select written while a channel runs takes effect at the first period boundary after the write. The period in progress completes with the old values.
- R9: The clock cycle after a write clears a channel's run bit, its output is low, and it stays low while the channel is disabled.
- R10: The four channels run independently and may be enabled together with different settings.
- R11: Read data is valid in the same cycle as the read strobe and is zero when no read strobe is asserted.
- R12: After the write that sets a run bit, the output is low for one cycle. A fresh period then begins, using the register values present at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| pwm_o | output | 4 | PWM outputs, one per channel |

## Verification
The counter-range property assumes that a channel's copied period length is never changed except at a boundary or a fresh start. The reload property assumes the prescaler is the only source of boundaries. The stimulus therefore writes settings only through the register port and never forces internal state. The bench keeps every high time within the period length, except where it tests the full-high case. It times mid-period writes so that they land strictly between two period boundaries, which leaves exactly one valid reload point to predict.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  localparam int PS_W  = 2;
  localparam int PRE_W = 9;

  typedef enum logic [PS_W-1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV8   = 2'd1,
    PS_DIV64  = 2'd2,
    PS_DIV512 = 2'd3
  } ps_sel_e;

  function automatic logic [PRE_W-1:0] pre_limit(ps_sel_e sel);
    case (sel)
      PS_DIV1:   return PRE_W'(0);
      PS_DIV8:   return PRE_W'(7);
      PS_DIV64:  return PRE_W'(63);
      default:   return PRE_W'(511);
    endcase
  endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CH-1:0]             en_o,
  output logic [NUM_CH-1:0][PS_W-1:0]   ps_o,
  output logic [NUM_CH-1:0][TB_W-1:0]   tb_o,
  output logic [NUM_CH-1:0][TB_W-1:0]   du_o
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int PS_LSB   = NUM_CH;
  localparam int DUTY_LSB = DATA_W / 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             ctrl_hit;
  logic             wdata_unused;

  assign idx          = addr_i[ADDR_W-1:2];
  assign aligned      = (addr_i[1:0] == 2'b00);
  assign ctrl_hit     = aligned && (idx == '0);
  assign wdata_unused = ^wdata_i;

  logic [NUM_CH-1:0]           en_q;
  logic [NUM_CH-1:0][PS_W-1:0] ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      ps_q <= '0;
    end else if (wr_en_i && ctrl_hit) begin
      en_q <= wdata_i[NUM_CH-1:0];
      ps_q <= wdata_i[PS_LSB +: PS_W*NUM_CH];
    end
  end

  logic [NUM_CH-1:0][TB_W-1:0] tb_q;
  logic [NUM_CH-1:0][TB_W-1:0] du_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
    logic cfg_hit;
    assign cfg_hit = aligned && (idx == IDX_W'(n + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tb_q[n] <= '0;
        du_q[n] <= '0;
      end else if (wr_en_i && cfg_hit) begin
        tb_q[n] <= wdata_i[TB_W-1:0];
        du_q[n] <= wdata_i[DUTY_LSB +: TB_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (ctrl_hit) begin
        rdata_o[NUM_CH-1:0]               = en_q;
        rdata_o[PS_LSB +: PS_W*NUM_CH]    = ps_q;
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if (aligned && idx == IDX_W'(n + 1)) begin
          rdata_o[TB_W-1:0]          = tb_q[n];
          rdata_o[DUTY_LSB +: TB_W]  = du_q[n];
        end
      end
    end
  end

  assign en_o = en_q;
  assign ps_o = ps_q;
  assign tb_o = tb_q;
  assign du_o = du_q;

  // R2
  ctrl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ctrl_hit |=> en_o == $past(wdata_i[NUM_CH-1:0]));

  // R11
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);

endmodule

// File: rtl/pwm_quad_prescaler.sv
module pwm_quad_prescaler
  import pwm_quad_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clear_i,
  input  ps_sel_e sel_i,
  output logic    tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = pre_limit(sel_i);
  assign tick_o = !clear_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i || tick_o) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  // R4
  pre_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> pre_q == '0);

  // R12
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> pre_q == '0);

endmodule

// File: rtl/pwm_quad_channel.sv
module pwm_quad_channel
  import pwm_quad_pkg::*;
#(
  parameter int TB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic [TB_W-1:0] du_i,
  input  ps_sel_e         sel_i,
  output logic            pwm_o
);

  logic            run_q;
  logic [TB_W-1:0] cnt_q;
  logic [TB_W-1:0] tb_s;
  logic [TB_W-1:0] du_s;
  ps_sel_e         ps_s;
  logic            tick;
  logic            clr;
  logic            last;

  assign clr  = !en_i || !run_q;
  assign last = (tb_s == '0) || (cnt_q == tb_s - 1'b1);

  pwm_quad_prescaler u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clr),
    .sel_i   (ps_s),
    .tick_o  (tick)
  );

  // shadow copies load only on a fresh start or at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tb_s  <= '0;
      du_s  <= '0;
      ps_s  <= PS_DIV1;
    end else if (!en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      tb_s  <= tb_i;
      du_s  <= du_i;
      ps_s  <= sel_i;
    end else if (tick) begin
      if (last) begin
        cnt_q <= '0;
        tb_s  <= tb_i;
        du_s  <= du_i;
        ps_s  <= sel_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwm_o = en_i && run_q && (tb_s != '0) && (cnt_q < du_s);

  // R5
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && tb_s != '0 |-> cnt_q < tb_s);

  // R8
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(run_q) && !$stable({tb_s, du_s, ps_s}) |-> $past(tick));

  // R9
  off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0 && !run_q);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);

  logic [NUM_CH-1:0]           en;
  logic [NUM_CH-1:0][PS_W-1:0] ps;
  logic [NUM_CH-1:0][TB_W-1:0] tb;
  logic [NUM_CH-1:0][TB_W-1:0] du;

  pwm_quad_regs #(
    .NUM_CH (NUM_CH),
    .TB_W   (TB_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .ps_o    (ps),
    .tb_o    (tb),
    .du_o    (du)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pwm_quad_channel #(
      .TB_W (TB_W)
    ) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[n]),
      .tb_i   (tb[n]),
      .du_i   (du[n]),
      .sel_i  (ps_sel_e'(ps[n])),
      .pwm_o  (pwm_o[n])
    );
  end

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> pwm_o == '0);

endmodule

// File: tb/pwm_quad_tb.sv
`timescale 1ns/1ps
module pwm_quad_tb;

  logic        clk_i   = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i  = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  pwm_o;

  always #2.5 clk_i = ~clk_i;

  pwm_quad u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pwm_o   (pwm_o)
  );

  typedef struct {
    logic [3:0] v;
    string      tag;
  } item_t;

  item_t stage_q[$];
  item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;

  int tb_p[4];
  int du_p[4];
  int dv_p[4];
  bit en_p[4];

  function automatic logic [3:0] vec(int k);
    logic [3:0] v = '0;
    for (int c = 0; c < 4; c++)
      if (en_p[c] && tb_p[c] > 0 && ((k / dv_p[c]) % tb_p[c]) < du_p[c]) v[c] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] cfg(int tb, int du);
    return (32'(du) << 16) | 32'(tb);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stage_start(string tag);
    item_t it;
    it.v = 4'b0000; it.tag = tag;
    stage_q.push_back(it);
  endtask

  task automatic stage(int n, string tag);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.v = vec(i); it.tag = tag;
      stage_q.push_back(it);
    end
  endtask

  // write; when commit is set the staged items go live in the same step
  task automatic reg_wr(logic [7:0] a, logic [31:0] d, bit commit);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    if (commit) while (stage_q.size() > 0) exp_q.push_back(stage_q.pop_front());
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    #1;
    check(rdata_o, e, tag);
    rd_en_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
  endtask

  task automatic all_off();
    for (int c = 0; c < 4; c++) begin
      en_p[c] = 1'b0; tb_p[c] = 0; du_p[c] = 0; dv_p[c] = 1;
    end
  endtask

  // monitor: one expected output vector per cycle
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check({28'b0, pwm_o}, {28'b0, it.v}, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    all_off();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check({28'b0, pwm_o}, 32'h0, "R1 outputs");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h10, 32'h0, "R1 cfg3");
    // R11 no strobe gives zero
    @(negedge clk_i);
    addr_i = 8'h00; #1;
    check(rdata_o, 32'h0, "R11 idle");

    // R3 field layout and masking
    reg_wr(8'h04, 32'hAB12_CD05, 0);
    rd(8'h04, 32'h0012_0005, "R3 cfg0 mask");
    // R2 ctrl layout and masking
    reg_wr(8'h00, 32'hFFFF_FAA0, 0);
    rd(8'h00, 32'h0000_0AA0, "R2 ctrl mask");
    // R3 unmapped and misaligned ignored
    reg_wr(8'h24, 32'h1234_5678, 0);
    rd(8'h24, 32'h0, "R3 unmapped read");
    reg_wr(8'h05, 32'h00FF_00FF, 0);
    rd(8'h04, 32'h0012_0005, "R3 misaligned write");
    reg_wr(8'h00, 32'h0, 0);

    // R5 R4 R6 R10 R12: all channels together
    reg_wr(8'h04, cfg(5, 2), 0);
    reg_wr(8'h08, cfg(3, 2), 0);
    reg_wr(8'h0C, cfg(4, 0), 0);
    reg_wr(8'h10, cfg(4, 4), 0);
    for (int c = 0; c < 4; c++) en_p[c] = 1'b1;
    tb_p = '{5, 3, 4, 4};
    du_p = '{2, 2, 0, 4};
    dv_p = '{1, 8, 1, 1};
    stage_start("R12 start low");
    stage(80, "R5 R4 R6 R10");
    reg_wr(8'h00, 32'h0000_004F, 1);
    drain();

    // R9 disable forces low
    all_off();
    stage(12, "R9");
    reg_wr(8'h00, 32'h0, 1);
    drain();

    // R7 zero period length
    reg_wr(8'h04, cfg(0, 3), 0);
    en_p[0] = 1'b1; tb_p[0] = 0; du_p[0] = 3;
    stage_start("R7");
    stage(20, "R7");
    reg_wr(8'h00, 32'h1, 1);
    drain();

    // R8 mid-period cfg change
    reg_wr(8'h00, 32'h0, 0);
    reg_wr(8'h04, cfg(4, 1), 0);
    all_off();
    en_p[0] = 1'b1; tb_p[0] = 4; du_p[0] = 1;
    stage_start("R8 cfg");
    stage(12, "R8 cfg old");
    tb_p[0] = 6; du_p[0] = 3;
    stage(18, "R8 cfg new");
    reg_wr(8'h00, 32'h1, 1);
    repeat (8) @(negedge clk_i);
    reg_wr(8'h04, cfg(6, 3), 0);
    drain();

    // R8 mid-period step select change
    reg_wr(8'h00, 32'h0, 0);
    reg_wr(8'h08, cfg(2, 1), 0);
    all_off();
    en_p[1] = 1'b1; tb_p[1] = 2; du_p[1] = 1; dv_p[1] = 1;
    stage_start("R8 sel");
    stage(10, "R8 sel old");
    dv_p[1] = 8;
    stage(32, "R8 sel new");
    reg_wr(8'h00, 32'h2, 1);
    repeat (8) @(negedge clk_i);
    reg_wr(8'h00, 32'h42, 0);
    drain();

    // R4 large step sizes
    reg_wr(8'h00, 32'h0, 0);
    reg_wr(8'h0C, cfg(3, 1), 0);
    reg_wr(8'h10, cfg(2, 1), 0);
    all_off();
    en_p[2] = 1'b1; tb_p[2] = 3; du_p[2] = 1; dv_p[2] = 64;
    en_p[3] = 1'b1; tb_p[3] = 2; du_p[3] = 1; dv_p[3] = 512;
    stage_start("R4 div64/512");
    stage(1100, "R4 div64/512");
    reg_wr(8'h00, 32'h0000_0E0C, 1);
    drain();
    rd(8'h00, 32'h0000_0E0C, "R11 ctrl readback");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule